// File: doc/BRIEF.md
# Framed Serial Audio Word Receiver

This block takes stereo samples from a serial converter link and turns each one into a word that a host can read. The link has four wires: a bit clock, a frame strobe, a channel-select level and serial data. All four are asynchronous to the system clock. Each passes through a two-flop synchronizer, and the bit clock and frame strobe are then edge-detected in the system clock domain.

A rising edge of the frame strobe opens a capture window. The window takes exactly the next 24 serial bits, MSB first, each sampled on a rising edge of the bit clock. When the window closes, the 24-bit result moves to a holding register. The upper 16 bits keep the converter word and the low byte is forced to zero. The word is tagged as left or right. The tag comes either from the channel-select level at frame start or, in the alternate mode, from a toggle that starts at left after reset. A ready flag is raised. If interrupts are enabled, an interrupt request is also raised. The host reads a data register and a status register through a simple read port.

Top module: `swrx_top`

## Requirements
- R1: After reset the status register reads 0 (ready, overrun and tag bits clear) and `irq` is low.
- R2: Bit-clock rising edges that arrive while no capture window is open shift nothing, and ready stays 0.
- R3: After a frame-strobe rising edge, the next 24 bit-clock rising edges sample `serialData`. The first bit sampled becomes bit 23 of the result (MSB first).
- R4: Data register bits 23:8 hold the first 16 bits received, bits 7:0 read as zero, and bits 31:25 read as zero.
- R5: Status bit 0 (ready) is set when a word moves to the holding register. It is cleared by a read of address 0 (data).
- R6: A transfer raises `irq` only if `cfgIntEnable` is 1. A read of address 0 clears `irq`.
- R7: With `cfgToggleMode` = 0, the `chanSel` level at frame start becomes the tag (1 = left). The tag appears in data bit 24 and status bit 2.
- R8: With `cfgToggleMode` = 1, the first word after reset is tagged left (1), and each later word takes the opposite tag of the word before it, whatever `chanSel` is.
- R9: A transfer that finds ready still set sets status bit 1 (overrun), and the data register holds the newer word. A read of address 1 (status) returns the overrun bit and then clears it.
- R10: Frame-strobe rising edges inside an open window are ignored. The window still ends after 24 bits and produces exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| bitClk | input | 1 | Serial bit clock, asynchronous |
| frameStrobe | input | 1 | Frame start strobe, rising edge opens a window |
| chanSel | input | 1 | Channel level, 1 = left |
| serialData | input | 1 | Serial sample data, MSB first |
| cfgIntEnable | input | 1 | Enables the interrupt on transfer |
| cfgToggleMode | input | 1 | Selects toggle-based channel tagging |
| rdEn | input | 1 | Register read strobe (read side effects) |
| rdAddr | input | 1 | 0 = data register, 1 = status register |
| rdData | output | 32 | Register read value for `rdAddr` |
| irq | output | 1 | Interrupt request |

## Verification
The capture path is driven with a directed word whose alternating nibbles expose bit-order and byte-position errors. It is also driven with seeded random words and random channel levels, which separate a correct MSB-first shift from a reversed or shifted one. Stray bit-clock pulses with no frame edge, and a frame re-strobe in mid-window, distinguish a receiver that only counts from one that waits for the frame edge. Two back-to-back words with no read in between expose the overrun flag and show which word survives. A run in toggle mode with a fixed channel level separates the toggle tag from the sampled level.

// File: rtl/swrx_pkg.sv
package swrx_pkg;
  typedef struct packed {
    logic shift;      // take one serial bit
    logic latchChan;  // window opens: capture channel level
    logic load;       // move shift register into holding register
  } swrxStrobe_t;
endpackage

// File: rtl/swrx_sync.sv
module swrx_sync #(
  parameter int N_SIG  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_SIG-1:0] rawIn,
  output logic [N_SIG-1:0] syncOut,
  output logic [N_SIG-1:0] prevOut
);
  logic [STAGES-1:0][N_SIG-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe    <= '0;
      prevOut <= '0;
    end else begin
      pipe[0] <= rawIn;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prevOut <= pipe[STAGES-1];
    end
  end

  assign syncOut = pipe[STAGES-1];
endmodule

// File: rtl/swrx_ctrl.sv
module swrx_ctrl
  import swrx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitS,
  input  logic        bitPrev,
  input  logic        frameS,
  input  logic        framePrev,
  input  logic        rdEn,
  input  logic        rdAddr,
  input  logic        cfgIntEnable,
  output swrxStrobe_t stb,
  output logic        ready,
  output logic        overrun,
  output logic        irq
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic             busy;
  logic [CNT_W-1:0] bitCnt;
  logic             loadPend;
  logic             bitRise, frameRise, start, lastBit, dataRd, statRd;

  assign bitRise   = bitS & ~bitPrev;
  assign frameRise = frameS & ~framePrev;
  assign start     = frameRise & ~busy;
  assign dataRd    = rdEn & ~rdAddr;
  assign statRd    = rdEn & rdAddr;

  always_comb begin
    stb.shift     = bitRise & (busy | start);
    stb.latchChan = start;
    stb.load      = loadPend;
    lastBit       = stb.shift && (bitCnt == CNT_W'(WORD_W - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      bitCnt   <= '0;
      loadPend <= 1'b0;
      ready    <= 1'b0;
      overrun  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (lastBit)    busy <= 1'b0;
      else if (start) busy <= 1'b1;

      if (stb.shift) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;

      loadPend <= lastBit;

      if (stb.load)   ready <= 1'b1;
      else if (dataRd) ready <= 1'b0;

      if (stb.load && ready) overrun <= 1'b1;
      else if (statRd)       overrun <= 1'b0;

      if (stb.load && cfgIntEnable) irq <= 1'b1;
      else if (dataRd)              irq <= 1'b0;
    end
  end

  assert_load_sets_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> ready);
  assert_irq_implies_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ready);
  assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < CNT_W'(WORD_W));
  assert_overrun_on_busy_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && ready) |=> overrun);
  assert_no_restart_midwindow_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && frameRise && !stb.shift) |=> $stable(bitCnt));
endmodule

// File: rtl/swrx_dpath.sv
module swrx_dpath
  import swrx_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int FILL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  swrxStrobe_t       stb,
  input  logic              dataS,
  input  logic              chanS,
  input  logic              cfgToggleMode,
  output logic [WORD_W-1:0] holdWord,
  output logic              holdLeft
);
  localparam int KEEP_W = WORD_W - FILL_W;

  logic [WORD_W-1:0] shiftReg;
  logic              chanLatched;
  logic              toggleFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      chanLatched <= 1'b0;
      toggleFlag  <= 1'b1;
      holdWord    <= '0;
      holdLeft    <= 1'b0;
    end else begin
      if (stb.shift)     shiftReg    <= {shiftReg[WORD_W-2:0], dataS};
      if (stb.latchChan) chanLatched <= chanS;
      if (stb.load) begin
        holdWord   <= {shiftReg[WORD_W-1:FILL_W], {FILL_W{1'b0}}};
        holdLeft   <= cfgToggleMode ? toggleFlag : chanLatched;
        toggleFlag <= ~toggleFlag;
      end
    end
  end

  assert_keep_upper_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> holdWord[WORD_W-1:FILL_W] == $past(shiftReg[WORD_W-1:FILL_W]));
  assert_toggle_flips_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> toggleFlag != $past(toggleFlag));
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(holdWord));

  if (KEEP_W < 1) begin : g_badWidth
    initial $display("swrx_dpath: FILL_W leaves no kept bits");
  end
endmodule

// File: rtl/swrx_top.sv
module swrx_top
  import swrx_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int FILL_W = 8,
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitClk,
  input  logic        frameStrobe,
  input  logic        chanSel,
  input  logic        serialData,
  input  logic        cfgIntEnable,
  input  logic        cfgToggleMode,
  input  logic        rdEn,
  input  logic        rdAddr,
  output logic [31:0] rdData,
  output logic        irq
);
  localparam int N_SIG = 4;
  localparam int PAD_W = 32 - WORD_W - 1;

  logic [N_SIG-1:0] syncV, prevV;
  swrxStrobe_t      stb;
  logic [WORD_W-1:0] holdWord;
  logic             holdLeft, ready, overrun;

  swrx_sync #(.N_SIG(N_SIG), .STAGES(STAGES)) u_sync (
    .clk(clk), .rstN(rstN),
    .rawIn({serialData, chanSel, frameStrobe, bitClk}),
    .syncOut(syncV), .prevOut(prevV)
  );

  swrx_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .bitS(syncV[0]), .bitPrev(prevV[0]),
    .frameS(syncV[1]), .framePrev(prevV[1]),
    .rdEn(rdEn), .rdAddr(rdAddr), .cfgIntEnable(cfgIntEnable),
    .stb(stb), .ready(ready), .overrun(overrun), .irq(irq)
  );

  swrx_dpath #(.WORD_W(WORD_W), .FILL_W(FILL_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .dataS(syncV[3]), .chanS(syncV[2]), .cfgToggleMode(cfgToggleMode),
    .holdWord(holdWord), .holdLeft(holdLeft)
  );

  always_comb begin
    if (rdAddr) rdData = {29'd0, holdLeft, overrun, ready};
    else        rdData = {{PAD_W{1'b0}}, holdLeft, holdWord};
  end
endmodule

// File: tb/sim_swrx_top.sv
module sim_swrx_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClk = 1'b0, frameStrobe = 1'b0, chanSel = 1'b0, serialData = 1'b0;
  logic cfgIntEnable = 1'b1, cfgToggleMode = 1'b0;
  logic rdEn = 1'b0, rdAddr = 1'b0;
  logic [31:0] rdData;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  swrx_top u0 (.*);

  function automatic logic [31:0] expData(input logic [23:0] w, input logic left);
    return {7'd0, left, w[23:8], 8'h00};
  endfunction

  function automatic logic [31:0] expStat(input logic left, input logic ovr, input logic rdy);
    return {29'd0, left, ovr, rdy};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic addr, output logic [31:0] val);
    @(negedge clk);
    rdAddr = addr; rdEn = 1'b1;
    #1 val = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulseBit();
    repeat (4) @(negedge clk);
    bitClk = 1'b1;
    repeat (4) @(negedge clk);
    bitClk = 1'b0;
  endtask

  task automatic sendWord(input logic [23:0] w, input logic chan, input bit glitch);
    chanSel = chan;
    @(negedge clk);
    frameStrobe = 1'b1;
    for (int i = 23; i >= 0; i--) begin
      serialData = w[i];
      if (glitch && i == 15) frameStrobe = 1'b0;
      if (glitch && i == 10) frameStrobe = 1'b1;
      pulseBit();
    end
    frameStrobe = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [23:0] w, w2;
    logic c, ie;
    void'($urandom(32'd4242));
    doReset();

    // R1 reset state
    readReg(1'b1, v); check("R1 status", v, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R2 stray bit clocks without a frame edge
    for (int k = 0; k < 30; k++) pulseBit();
    repeat (10) @(negedge clk);
    readReg(1'b1, v); check("R2 no capture", v, 32'd0);

    // R3 R4 R5 R6 R7 directed word
    w = 24'hA5C3F0;
    sendWord(w, 1'b1, 0);
    check("R6 irq raised", {31'd0, irq}, 32'd1);
    readReg(1'b1, v); check("R5 R7 status", v, expStat(1'b1, 1'b0, 1'b1));
    readReg(1'b0, v); check("R3 R4 R7 data", v, expData(w, 1'b1));
    readReg(1'b1, v); check("R5 ready cleared", v, expStat(1'b1, 1'b0, 1'b0));
    check("R6 irq cleared", {31'd0, irq}, 32'd0);

    // random words, channels and interrupt enable
    for (int n = 0; n < 10; n++) begin
      w = 24'($urandom); c = 1'($urandom); ie = 1'($urandom);
      cfgIntEnable = ie;
      sendWord(w, c, 0);
      check("R6 irq follows enable", {31'd0, irq}, {31'd0, ie});
      readReg(1'b0, v); check("R3 R4 R7 random data", v, expData(w, c));
      readReg(1'b1, v); check("R5 R7 after read", v, expStat(c, 1'b0, 1'b0));
    end
    cfgIntEnable = 1'b1;

    // R10 frame re-strobe inside window
    w = 24'h3C96E1;
    sendWord(w, 1'b0, 1);
    readReg(1'b1, v); check("R10 one word no overrun", v, expStat(1'b0, 1'b0, 1'b1));
    readReg(1'b0, v); check("R10 data", v, expData(w, 1'b0));

    // R9 overrun
    w = 24'h123456; w2 = 24'hFEDCBA;
    sendWord(w, 1'b1, 0);
    sendWord(w2, 1'b0, 0);
    readReg(1'b1, v); check("R9 overrun set", v, expStat(1'b0, 1'b1, 1'b1));
    readReg(1'b1, v); check("R9 overrun cleared", v, expStat(1'b0, 1'b0, 1'b1));
    readReg(1'b0, v); check("R9 newest word kept", v, expData(w2, 1'b0));

    // R8 toggle mode
    cfgToggleMode = 1'b1;
    doReset();
    for (int n = 0; n < 4; n++) begin
      w = 24'($urandom);
      sendWord(w, 1'b0, 0);
      readReg(1'b0, v);
      check("R8 toggle tag", v, expData(w, (n % 2 == 0)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule